// File: doc/BRIEF.md
# Parity-Compressed Counter Array

This block holds a large array of free-running 8-bit counters and exposes their combined state on a narrow bus. Every counter folds its eight bits into a single parity bit. The parity bits are then narrowed by three rounds of pairwise XOR, and each round halves the number of bits. The result is one output bit per group of eight adjacent counters. A flip of any single bit anywhere in the array therefore flips exactly one output bit.

The block has no data inputs. It runs from a clock and a synchronous active-high reset. It is meant to be placed next to an identical copy, so that a comparator can spot any divergence between the two. The output is registered and trails the counter state by one cycle. A stride parameter can give each counter its own reset value. With the default stride of zero, every counter starts at zero and the output stays at zero.

Top module: `parity_counter_array`

## Requirements
- R1: While `rst` is high at a rising edge, every counter loads its start value and `parity_o` is cleared to all zeros on that edge.
- R2: With `rst` low, every counter adds one on each rising edge and wraps from 255 to 0.
- R3: The parity bit of a counter is the XOR of all 8 bits of its current value.
- R4: Each reduction round XORs neighbouring bits at indices 2i and 2i+1 into bit i. Three rounds are applied, so `parity_o[j]` is the XOR of the parity bits of counters 8j through 8j+7.
- R5: `parity_o` is registered. At an edge where `rst` is low, it takes the reduced value of the counter contents held just before that edge.
- R6: `COUNTERS` must be a multiple of 8, and `parity_o` is `COUNTERS/8` bits wide.
- R7: With `START_STRIDE` = 0 (all counters start at zero), `parity_o` is zero on every cycle.
- R8: Counter i resets to (i * `START_STRIDE`) mod 256.
- R9: When reset arrives on the edge where the counters would wrap, reset takes priority. The counters load their start values, and `parity_o` is zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| parity_o | output | COUNTERS/8 | Registered, compressed parity of the counter array |

## Verification
Two actions can fall on the same edge: the wrap of every counter from 255 to 0, and the synchronous reset. The bench tracks how many steps have passed since reset. It raises `rst` exactly on the edge where that count reaches 255, which is also the edge where the counters would wrap. It then checks that the output is zero on that edge and that, after release, the sequence restarts from the start values rather than from the wrapped ones. A second instance with a nonzero stride is used so that the output pattern is not trivially constant.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CNT_W       = 8;
  localparam int TREE_LEVELS = 3;
  localparam int GROUP       = 1 << TREE_LEVELS;

  function automatic logic [CNT_W-1:0] start_value(input int idx, input int stride);
    int v;
    v = (idx * stride) % (1 << CNT_W);
    return CNT_W'(v);
  endfunction
endpackage

// File: rtl/pca_counter_cell.sv
module pca_counter_cell #(
  parameter int            CW    = 8,
  parameter logic [CW-1:0] START = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] value,
  output logic          parity
);
  always_ff @(posedge clk) begin
    if (rst) value <= START;
    else     value <= value + 1'b1;
  end

  always_comb parity = ^value;
endmodule

// File: rtl/pca_xor_halver.sv
module pca_xor_halver #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]   din,
  output logic [IN_W/2-1:0] dout
);
  localparam int OUT_W = IN_W / 2;

  for (genvar i = 0; i < OUT_W; i++) begin : g_pair
    assign dout[i] = din[2*i] ^ din[2*i+1];
  end
endmodule

// File: rtl/parity_counter_array.sv
module parity_counter_array
  import pca_pkg::*;
#(
  parameter int COUNTERS     = 400,
  parameter int START_STRIDE = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [COUNTERS/GROUP-1:0]   parity_o
);
  localparam int W0 = COUNTERS;
  localparam int W1 = W0 / 2;
  localparam int W2 = W1 / 2;
  localparam int W3 = W2 / 2;

  if (COUNTERS % GROUP != 0) begin : g_bad_count
    $error("COUNTERS must be a multiple of 8");
  end

  logic [COUNTERS*CNT_W-1:0] cnt_flat;
  logic [W0-1:0]             par_bits;
  logic [W1-1:0]             lvl1;
  logic [W2-1:0]             lvl2;
  logic [W3-1:0]             lvl3;

  for (genvar i = 0; i < COUNTERS; i++) begin : g_cell
    pca_counter_cell #(
      .CW    (CNT_W),
      .START (start_value(i, START_STRIDE))
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .value  (cnt_flat[i*CNT_W +: CNT_W]),
      .parity (par_bits[i])
    );
  end

  pca_xor_halver #(.IN_W(W0)) u_lvl1 (.din(par_bits), .dout(lvl1));
  pca_xor_halver #(.IN_W(W1)) u_lvl2 (.din(lvl1),     .dout(lvl2));
  pca_xor_halver #(.IN_W(W2)) u_lvl3 (.din(lvl2),     .dout(lvl3));

  always_ff @(posedge clk) begin
    if (rst) parity_o <= '0;
    else     parity_o <= lvl3;
  end
endmodule

// File: rtl/parity_counter_array_chk.sv
module parity_counter_array_chk
  import pca_pkg::*;
#(
  parameter int COUNTERS     = 400,
  parameter int START_STRIDE = 0
) (
  input logic                        clk,
  input logic                        rst,
  input logic [COUNTERS/GROUP-1:0]   parity_o,
  input logic [COUNTERS*CNT_W-1:0]   cnt_flat
);
  localparam int LAST = COUNTERS - 1;
  localparam logic [CNT_W-1:0] LAST_START = start_value(LAST, START_STRIDE);

  // R1: output cleared by reset
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> parity_o == '0);

  // R2: counter 0 and the last counter step by one with wrap
  p_step_first_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_flat[CNT_W-1:0] == CNT_W'($past(cnt_flat[CNT_W-1:0]) + 1));
  p_step_last_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_flat[LAST*CNT_W +: CNT_W] ==
                    CNT_W'($past(cnt_flat[LAST*CNT_W +: CNT_W]) + 1));

  // R4/R5: each output bit is the parity of its eight-counter group one edge earlier
  for (genvar j = 0; j < COUNTERS/GROUP; j++) begin : g_grp
    p_group_parity_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> parity_o[j] == ^$past(cnt_flat[j*GROUP*CNT_W +: GROUP*CNT_W]));
  end

  // R8: start values after reset
  p_start_first_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cnt_flat[CNT_W-1:0] == '0);
  p_start_last_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cnt_flat[LAST*CNT_W +: CNT_W] == LAST_START);

  // R7: equal start values keep the output at zero
  if (START_STRIDE == 0) begin : g_flat
    p_flat_zero_r7: assert property (@(posedge clk) disable iff (rst)
      parity_o == '0);
  end
endmodule

bind parity_counter_array parity_counter_array_chk #(
  .COUNTERS     (COUNTERS),
  .START_STRIDE (START_STRIDE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .parity_o (parity_o),
  .cnt_flat (cnt_flat)
);

// File: tb/test_parity_counter_array.sv
module test_parity_counter_array;
  localparam int NA = 400;
  localparam int NB = 64;
  localparam int SB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NA/8-1:0] q_a;
  logic [NB/8-1:0] q_b;

  always #2 clk = ~clk;

  parity_counter_array i_parity_counter_array (
    .clk(clk), .rst(rst), .parity_o(q_a));

  parity_counter_array #(.COUNTERS(NB), .START_STRIDE(SB)) i_parity_counter_array_s (
    .clk(clk), .rst(rst), .parity_o(q_b));

  int    vectors = 0;
  int    errors  = 0;
  int    steps   = 0;
  bit    primed  = 1'b0;
  bit    done    = 1'b0;
  string tag     = "R1";
  logic [63:0] exp_a = '0;
  logic [63:0] exp_b = '0;

  // Behavioural reference: counter i holds (start_i + steps) mod 256
  function automatic logic [63:0] ref_word(input int n, input int stride, input int t);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < n/8; j++) begin
      for (int i = 0; i < 8; i++) begin
        int v;
        v = ((8*j + i) * stride + t) % 256;
        r[j] = r[j] ^ ($countones(v[7:0]) % 2 == 1);
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_a = '0;
      exp_b = '0;
      steps = 0;
    end else begin
      exp_a = ref_word(NA, 0, steps);
      exp_b = ref_word(NB, SB, steps);
      steps = steps + 1;
    end
    primed = 1'b1;
  end

  always @(negedge clk) begin
    if (primed && !done) begin
      vectors++;
      if (q_a !== exp_a[NA/8-1:0]) begin
        errors++;
        $display("FAIL R7 (%s) flat array: got %h expected %h", tag, q_a, exp_a[NA/8-1:0]);
      end
      vectors++;
      if (q_b !== exp_b[NB/8-1:0]) begin
        errors++;
        $display("FAIL %s strided array: got %h expected %h", tag, q_b, exp_b[NB/8-1:0]);
      end
    end
  end

  initial begin
    // R6: output widths follow COUNTERS/8
    vectors++;
    if ($bits(q_a) != 50 || $bits(q_b) != 8) begin
      errors++;
      $display("FAIL R6 widths: got %0d/%0d expected 50/8", $bits(q_a), $bits(q_b));
    end
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R5";
    repeat (2) @(negedge clk);
    tag = "R8";
    repeat (10) @(negedge clk);
    tag = "R3";
    repeat (20) @(negedge clk);
    tag = "R2";
    repeat (300) @(negedge clk);
    // R9: reset on the edge where counter 0 of the flat array holds 255
    while (steps % 256 != 255) @(negedge clk);
    tag = "R9";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    tag = "R4";
    repeat (100) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule